// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This unit takes two single-precision floating-point words and returns either the smaller or the larger of the two. A one-bit select chooses minimum or maximum. A two-bit policy input chooses how NaN operands and signed zeros are treated. The unit supports three policies:

- the older missing-data style, where a quiet NaN is skipped but a signaling NaN poisons the result;
- the propagating style, where any NaN gives a NaN;
- the newer number-preferring style, where every NaN is skipped and a signaling NaN still raises invalid.

The operation is exact and needs no rounding. The unit computes the result combinationally and stores it, with an invalid-operation flag, in a register stage. A small output state machine produces a one-cycle output valid strobe. The machine has two states. `ST_IDLE` means no fresh result is presented. `ST_EMIT` means the registered result was captured on the previous edge. Its transitions are:

- `ST_IDLE -> ST_EMIT` on an accepted input.
- `ST_EMIT -> ST_EMIT` on a back-to-back input.
- `ST_EMIT -> ST_IDLE` when no input arrives.
- `ST_IDLE -> ST_IDLE` while the input is idle.

Top module: `fmm_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `out_valid`, `invalid` and `result` are all zero.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high. Results appear in input order.
- R3: For two non-NaN operands, including infinities, values are ordered as sign-magnitude numbers. `sel_max`=0 returns the smaller value and `sel_max`=1 returns the larger value.
- R4: Under every policy, -0.0 (32'h80000000) is ordered below +0.0 (32'h00000000), in either operand order.
- R5: A word is a NaN when bits 30:23 are all ones and bits 22:0 are nonzero. A NaN is signaling when bit 22 is 0. Every NaN result is exactly 32'h7FC00000, and no input payload is ever passed through.
- R6: Policy 2'b00 (missing-data style):
  - Any signaling NaN operand gives 32'h7FC00000.
  - Otherwise, two quiet NaNs give 32'h7FC00000.
  - Otherwise, a single quiet NaN is skipped and the other operand is returned.
- R7: Policy 2'b01 (propagating style): any NaN operand gives 32'h7FC00000.
- R8: Policy 2'b10 (number-preferring style):
  - One NaN operand, quiet or signaling, is skipped and the other operand is returned.
  - Two NaN operands give 32'h7FC00000.
  - Policy 2'b11 behaves identically.
- R9: Under every policy, `invalid` is 1 exactly when at least one operand is a signaling NaN. This holds even when the result is a number. The flag is reloaded on every accepted input and never accumulates.
- R10: In cycles without `in_valid`, the operand, select and policy inputs have no effect: `result` and `invalid` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands, select and policy are valid this cycle |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| sel_max | input | 1 | 0 returns minimum, 1 returns maximum |
| policy | input | 2 | NaN policy: 00 missing-data, 01 propagating, 10/11 number-preferring |
| out_valid | output | 1 | One-cycle strobe marking a fresh result |
| result | output | 32 | Registered minimum or maximum |
| invalid | output | 1 | Registered invalid-operation flag for that result |

## Verification
The output state machine holds only two states. If it were stuck in `ST_EMIT` or failed to leave `ST_IDLE`, `out_valid` would be wrong on the very next edge after an input or an idle cycle. The scoreboard would then see either an extra result with nothing expected or an expected item left unconsumed. A wrong policy decode or a wrong NaN classification shows up on the same cycle as the strobe for that input: the result carries the wrong operand or the wrong NaN, or `invalid` disagrees with the signaling inputs. A lost hold would let idle-cycle stimulus change `result` one edge later.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    // NaN handling policy selected per operation
    typedef enum logic [1:0] {
        POL_SKIP_QUIET = 2'b00,
        POL_PROPAGATE  = 2'b01,
        POL_SKIP_ALL   = 2'b10,
        POL_SKIP_ALL_B = 2'b11
    } nan_policy_e;

    // Per-operand classification
    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } opclass_t;

    // Output stage state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
    import fmm_pkg::*;
#(
    parameter int EW = fmm_pkg::EXP_W,
    parameter int FW = fmm_pkg::FRAC_W,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0] word,
    output opclass_t     cls
);
    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;

    always_comb begin
        exp_f       = word[W-2 -: EW];
        frac_f      = word[FW-1:0];
        cls.is_nan  = (&exp_f) && (|frac_f);
        // quiet bit is the top fraction bit
        cls.is_snan = cls.is_nan && !frac_f[FW-1];
    end
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
    parameter int W = fmm_pkg::WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_lt_b
);
    logic         sa, sb;
    logic [W-2:0] ma, mb;

    always_comb begin
        sa = a[W-1];
        sb = b[W-1];
        ma = a[W-2:0];
        mb = b[W-2:0];
        unique case ({sa, sb})
            2'b10:   a_lt_b = 1'b1;     // negative below positive, -0 below +0
            2'b01:   a_lt_b = 1'b0;
            2'b00:   a_lt_b = ma < mb;
            default: a_lt_b = ma > mb;  // both negative: larger magnitude is smaller
        endcase
    end
endmodule

// File: rtl/fmm_pick.sv
module fmm_pick
    import fmm_pkg::*;
#(
    parameter int EW = fmm_pkg::EXP_W,
    parameter int FW = fmm_pkg::FRAC_W,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  opclass_t     cls_a,
    input  opclass_t     cls_b,
    input  logic         a_lt_b,
    input  logic         sel_max,
    input  logic [1:0]   policy,
    output logic [W-1:0] res,
    output logic         inv
);
    localparam logic [W-1:0] CANON = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    logic [W-1:0] ordered;
    logic         any_nan, both_nan, any_snan;

    always_comb begin
        // equal values are identical words, so either pick is correct
        if (sel_max) ordered = a_lt_b ? b : a;
        else         ordered = a_lt_b ? a : b;

        any_nan  = cls_a.is_nan | cls_b.is_nan;
        both_nan = cls_a.is_nan & cls_b.is_nan;
        any_snan = cls_a.is_snan | cls_b.is_snan;
        inv      = any_snan;

        unique case (nan_policy_e'(policy))
            POL_SKIP_QUIET: begin
                if (any_snan || both_nan) res = CANON;
                else if (cls_a.is_nan)    res = b;
                else if (cls_b.is_nan)    res = a;
                else                      res = ordered;
            end
            POL_PROPAGATE: begin
                res = any_nan ? CANON : ordered;
            end
            POL_SKIP_ALL, POL_SKIP_ALL_B: begin
                if (both_nan)          res = CANON;
                else if (cls_a.is_nan) res = b;
                else if (cls_b.is_nan) res = a;
                else                   res = ordered;
            end
        endcase
    end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
#(
    parameter int EW = fmm_pkg::EXP_W,
    parameter int FW = fmm_pkg::FRAC_W,
    localparam int W = 1 + EW + FW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sel_max,
    input  logic [1:0]   policy,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         invalid
);
    logic [W-1:0] ops [2];
    opclass_t     cls [2];
    logic         a_lt_b;
    logic [W-1:0] pick_res;
    logic         pick_inv;
    out_state_e   state, state_nx;
    logic [W-1:0] res_q;
    logic         inv_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fmm_classify #(.EW(EW), .FW(FW)) u_cls (
            .word (ops[i]),
            .cls  (cls[i])
        );
    end

    fmm_order #(.W(W)) u_order (
        .a      (op_a),
        .b      (op_b),
        .a_lt_b (a_lt_b)
    );

    fmm_pick #(.EW(EW), .FW(FW)) u_pick (
        .a       (op_a),
        .b       (op_b),
        .cls_a   (cls[0]),
        .cls_b   (cls[1]),
        .a_lt_b  (a_lt_b),
        .sel_max (sel_max),
        .policy  (policy),
        .res     (pick_res),
        .inv     (pick_inv)
    );

    // next-state logic
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // result register, loaded only on accepted inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            inv_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= pick_res;
            inv_q <= pick_inv;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state == ST_EMIT);
        result    = res_q;
        invalid   = inv_q;
    end
endmodule

// File: rtl/fmm_unit_chk.sv
module fmm_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [1:0]   policy,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         invalid
);
    localparam int EW = 8;
    localparam logic [W-1:0] CANON = 32'h7FC00000;

    logic nan_a, nan_b, snan_a, snan_b, nan_r;

    always_comb begin
        nan_a  = (op_a[30:23] == 8'hFF) && (op_a[22:0] != '0);
        nan_b  = (op_b[30:23] == 8'hFF) && (op_b[22:0] != '0);
        snan_a = nan_a && !op_a[22];
        snan_b = nan_b && !op_b[22];
        nan_r  = (result[30:23] == 8'hFF) && (result[22:0] != '0);
    end

    // R2
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(invalid)));
    // R5
    a_r5_canonical: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && nan_r) |-> (result == CANON));
    // R9
    a_r9_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (invalid == $past(snan_a || snan_b)));
    // R7
    a_r7_propagate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && policy == 2'b01 && (nan_a || nan_b)) |=> (result == CANON));
    // R8
    a_r8_skip_a: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && policy[1] && nan_a && !nan_b) |=> (result == $past(op_b)));
endmodule

bind fmm_unit fmm_unit_chk #(.W(W)) u_fmm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .policy    (policy),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/tb_fmm_unit.sv
`timescale 1ns/1ps
module tb_fmm_unit;
    localparam real PERIOD = 4.0;
    localparam logic [31:0] CANON = 32'h7FC00000;
    localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
    localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
    localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
    localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
    localparam logic [31:0] QN = 32'h7FC00001, QN2 = 32'hFFC12345;
    localparam logic [31:0] SN = 32'h7F800001, SN2 = 32'hFFA00000;

    logic clk = 0, rst_n = 0, in_valid = 0, sel_max = 0;
    logic [31:0] op_a = 0, op_b = 0;
    logic [1:0]  policy = 0;
    logic        out_valid, invalid;
    logic [31:0] result;

    int checks = 0, errors = 0;

    typedef struct {
        logic [31:0] res;
        logic        inv;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(PERIOD/2) clk = ~clk;

    fmm_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sel_max(sel_max), .policy(policy), .out_valid(out_valid),
        .result(result), .invalid(invalid)
    );

    function automatic logic [31:0] okey(logic [31:0] x);
        return x[31] ? ~x : (x | 32'h80000000);
    endfunction

    function automatic logic is_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic mx,
                                   logic [1:0] pol, string tag);
        exp_t e;
        logic na, nb, sa, sb;
        logic [31:0] cmp;
        na = is_nan(a); nb = is_nan(b);
        sa = na && !a[22]; sb = nb && !b[22];
        if (mx) cmp = (okey(a) >= okey(b)) ? a : b;
        else    cmp = (okey(a) <= okey(b)) ? a : b;
        e.inv = sa | sb;
        e.tag = tag;
        if (pol == 2'b01)               e.res = (na | nb) ? CANON : cmp;
        else if (pol == 2'b00 && (sa | sb)) e.res = CANON;
        else if (na && nb)              e.res = CANON;
        else if (na)                    e.res = b;
        else if (nb)                    e.res = a;
        else                            e.res = cmp;
        return e;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic drive(logic [31:0] a, logic [31:0] b, logic mx,
                         logic [1:0] pol, string tag);
        @(negedge clk);
        op_a = a; op_b = b; sel_max = mx; policy = pol; in_valid = 1;
        sb_q.push_back(model(a, b, mx, pol, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    // monitor / scoreboard
    int strobes = 0;
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            strobes++;
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: actual out_valid 1 expected 0 (no pending item)");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " result"}, result, e.res);
                check({e.tag, " invalid (R9)"}, {31'b0, invalid}, {31'b0, e.inv});
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int sent;
        sent = 0;
        repeat (3) @(negedge clk);
        // R1: during reset
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        check("R1 invalid", {31'b0, invalid}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 out_valid after release", {31'b0, out_valid}, 32'd0);

        // R3: ordinary values, infinities
        drive(P1, P2, 0, 2'b00, "R3 min 1,2");
        drive(P1, P2, 1, 2'b00, "R3 max 1,2");
        drive(N1, N2, 0, 2'b01, "R3 min -1,-2");
        drive(N1, N2, 1, 2'b10, "R3 max -1,-2");
        drive(N1, P1, 0, 2'b10, "R3 min mixed sign");
        drive(PINF, NINF, 0, 2'b00, "R3 min infs");
        drive(NINF, P2, 1, 2'b01, "R3 max inf");
        drive(P2, P2, 1, 2'b00, "R3 equal");
        sent += 8;
        idle(1);
        // R4: signed zeros, all policies, both orders
        for (int p = 0; p < 4; p++) begin
            drive(PZ, NZ, 0, p[1:0], "R4 min +0,-0");
            drive(NZ, PZ, 0, p[1:0], "R4 min -0,+0");
            drive(PZ, NZ, 1, p[1:0], "R4 max +0,-0");
            drive(NZ, PZ, 1, p[1:0], "R4 max -0,+0");
            sent += 4;
        end
        idle(2);
        // R6: policy 00
        drive(QN, P1, 0, 2'b00, "R6 qnan skipped");
        drive(P2, QN2, 1, 2'b00, "R6 qnan skipped b");
        drive(SN, P1, 0, 2'b00, "R6 snan poisons");
        drive(QN, QN2, 1, 2'b00, "R6 two qnan");
        drive(P1, SN2, 1, 2'b00, "R6 snan b poisons");
        sent += 5;
        // R7: policy 01
        drive(QN, P1, 0, 2'b01, "R7 qnan propagates");
        drive(N2, SN, 1, 2'b01, "R7 snan propagates");
        drive(QN2, QN, 0, 2'b01, "R7 two nan");
        sent += 3;
        // R8: policy 10 and 11
        drive(SN, P1, 0, 2'b10, "R8 snan skipped");
        drive(N1, QN, 1, 2'b10, "R8 qnan skipped");
        drive(SN2, QN, 0, 2'b10, "R8 two nan");
        drive(SN, N2, 1, 2'b11, "R8 alt snan skipped");
        drive(QN, QN2, 1, 2'b11, "R8 alt two nan");
        sent += 5;
        // R9: flag not sticky; R5: canonical NaN payload
        drive(P1, P2, 0, 2'b10, "R9 flag cleared");
        drive(SN2, SN, 1, 2'b01, "R5 canonical from snans");
        sent += 2;
        idle(2);

        // R10: idle stimulus has no effect
        drive(SN, P2, 1, 2'b10, "R10 setup");
        sent += 1;
        idle(1);
        op_a = QN; op_b = N1; sel_max = 0; policy = 2'b01;
        repeat (3) begin
            @(negedge clk);
            op_a = op_a ^ 32'h00000F00;
            check("R10 result held", result, P2);
            check("R10 invalid held", {31'b0, invalid}, 32'd1);
            check("R10 no strobe (R2)", {31'b0, out_valid}, 32'd0);
        end
        idle(2);
        check("R2 strobe count", strobes, sent);
        check("R2 queue drained", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule